// File: doc/BRIEF.md
# Auto-Incrementing Work RAM Data Port

This block is a byte-wide register window through which a host processor streams data into or out of a work RAM without loading a new address for every byte. The host first builds a 17-bit pointer by writing up to three address registers, each of which replaces one byte-lane of the pointer. It then reads or writes a single data register repeatedly. Every data access reaches RAM at a fixed bank base (0x7E0000) ORed with the pointer, and the pointer then advances by one.

The RAM side is a synchronous port with one cycle of read latency. A data read issues a RAM read request in the strobe cycle, and the byte comes back on the register bus in the following cycle. In every cycle without a returning RAM byte, the read bus carries the open-bus byte supplied by the surrounding fabric. The address registers are write-only, so reading one of them also returns the open-bus byte.

Top module: `wram_port_top`

## Requirements
- R1: After reset the pointer is 0, so `ramAddr` reads 0x7E0000, `ramWe` and `ramRe` are 0, and `rdData` equals `openBus`.
- R2: A write with select 1 replaces pointer bits 7:0 with the data byte and keeps bits 16:8.
- R3: A write with select 2 replaces pointer bits 15:8 with the data byte and keeps bits 16 and 7:0.
- R4: A write with select 3 sets pointer bit 16 from data bit 0, ignores data bits 7:1, and keeps bits 15:0.
- R5: A write with select 0 (data register) drives `ramWe`=1, `ramWrData` equal to the data byte and `ramAddr` equal to 0x7E0000 OR pointer in the same cycle. The pointer is one higher from the next cycle on.
- R6: A read with select 0 drives `ramRe`=1 at 0x7E0000 OR pointer in the strobe cycle. `rdData` equals the RAM byte in the following cycle, and the pointer is one higher from the next cycle on. Back-to-back reads return consecutive bytes.
- R7: In any cycle that does not follow a data read, `rdData` equals `openBus`. A read with select 1, 2 or 3 does not touch RAM or the pointer.
- R8: Incrementing from pointer 0x1FFFF gives 0x00000, so the RAM address goes from 0x7FFFFF to 0x7E0000.
- R9: When an address-register write and a data-register read occur in the same cycle, the write wins. The read is dropped (no `ramRe`, open-bus data next cycle), and the pointer takes the loaded value with no increment.
- R10: When a data-register write and a data-register read occur in the same cycle, only the RAM write happens. The pointer increments once and no `ramRe` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Register write strobe |
| wrSel | input | 2 | Write register select: 0 data, 1 pointer low, 2 pointer middle, 3 pointer high |
| wrData | input | 8 | Register write byte |
| rdStb | input | 1 | Register read strobe |
| rdSel | input | 2 | Read register select, same encoding as `wrSel` |
| openBus | input | 8 | Byte returned when no RAM byte is due |
| rdData | output | 8 | Register read byte |
| ramAddr | output | 24 | RAM address, bank base ORed with the pointer |
| ramWrData | output | 8 | RAM write byte |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read request |
| ramRdData | input | 8 | RAM read byte, valid one cycle after `ramRe` |

## Verification
The RAM-side outputs (`ramWe`, `ramRe`, `ramAddr`, `ramWrData`) respond in the same cycle as a strobe, so the bench samples them one nanosecond after it drives the strobe. A pointer change becomes visible on `ramAddr` after the next rising edge, and the bench checks it after that edge and before it drives anything else. Each read strobe pushes its expected byte, either the shadow RAM byte or the open-bus byte, into a queue. A monitor pops that entry in the cycle after the strobe and compares it with `rdData` at mid-cycle. This lets back-to-back reads check out without any gap between them.

// File: rtl/wrdp_pkg.sv
package wrdp_pkg;
  localparam int DATA_W  = 8;
  localparam int PTR_W   = 17;
  localparam int RAM_AW  = 24;
  localparam int LANES   = (PTR_W + DATA_W - 1) / DATA_W;
  localparam int SEL_W   = $clog2(LANES + 1);
  localparam logic [RAM_AW-1:0] BANK_BASE = 24'h7E0000;

  // select 0 is the data register; select i+1 loads pointer byte-lane i
  localparam logic [SEL_W-1:0] SEL_DATA = '0;

  typedef struct packed {
    logic [LANES-1:0] load;     // per byte-lane pointer load
    logic             step;     // advance pointer by one
    logic             ramWrite; // data-register write reaches RAM
    logic             ramRead;  // data-register read reaches RAM
  } wrdpStrobes_t;
endpackage

// File: rtl/wrdp_ctrl.sv
module wrdp_ctrl
  import wrdp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             rdStb,
  input  logic [SEL_W-1:0] rdSel,
  output wrdpStrobes_t     st,
  output logic             rdPending
);
  logic dataWr;
  logic dataRd;
  logic anyLoad;

  for (genvar i = 0; i < LANES; i++) begin : g_laneDec
    assign st.load[i] = wrStb && (wrSel == SEL_W'(i + 1));
  end

  assign anyLoad = |st.load;
  assign dataWr  = wrStb && (wrSel == SEL_DATA);
  // any register write in the same cycle takes priority over a data read
  assign dataRd  = rdStb && (rdSel == SEL_DATA) && !wrStb;

  assign st.ramWrite = dataWr;
  assign st.ramRead  = dataRd;
  assign st.step     = (dataWr || dataRd) && !anyLoad;

  always_ff @(posedge clk) begin
    if (!rstN) rdPending <= 1'b0;
    else       rdPending <= dataRd;
  end

  AST_LOAD_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && wrSel != SEL_DATA && rdStb) |-> !st.ramRead && !st.step); // R9
  AST_SINGLE_RAM_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(st.ramWrite && st.ramRead)); // R10
  AST_PENDING_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!(rdStb && rdSel == SEL_DATA)) |=> !rdPending); // R7
endmodule

// File: rtl/wrdp_datapath.sv
module wrdp_datapath
  import wrdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrdpStrobes_t      st,
  input  logic              rdPending,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] openBus,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic              ramRe
);
  localparam int LOW_W = (LANES - 1) * DATA_W;

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrNext;

  always_comb begin
    ptrNext = ptr;
    if (|st.load) begin
      for (int b = 0; b < PTR_W; b++) begin
        if (st.load[b / DATA_W]) ptrNext[b] = wrData[b % DATA_W];
      end
    end else if (st.step) begin
      ptrNext = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  assign ramAddr   = BANK_BASE | RAM_AW'(ptr);
  assign ramWrData = wrData;
  assign ramWe     = st.ramWrite;
  assign ramRe     = st.ramRead;
  assign rdData    = rdPending ? ramRdData : openBus;

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && !(&ptr)) |=> ptr == $past(ptr) + 1'b1); // R5
  AST_POINTER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && (&ptr)) |=> ptr == '0); // R8
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (st.load == LANES'(1) << (LANES - 1)) |=> ptr[LOW_W-1:0] == $past(ptr[LOW_W-1:0])); // R4
  AST_LOW_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (st.load == LANES'(1)) |=> ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W])); // R2
  AST_READ_RETURNS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> rdData == ramRdData); // R6
  AST_BANK_ADDR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramRe) |-> ramAddr[RAM_AW-1:PTR_W] == BANK_BASE[RAM_AW-1:PTR_W]); // R5
endmodule

// File: rtl/wram_port_top.sv
module wram_port_top
  import wrdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic [DATA_W-1:0] openBus,
  output logic [DATA_W-1:0] rdData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic              ramRe,
  input  logic [DATA_W-1:0] ramRdData
);
  wrdpStrobes_t st;
  logic         rdPending;

  wrdp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .wrSel     (wrSel),
    .rdStb     (rdStb),
    .rdSel     (rdSel),
    .st        (st),
    .rdPending (rdPending)
  );

  wrdp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .rdPending (rdPending),
    .wrData    (wrData),
    .openBus   (openBus),
    .ramRdData (ramRdData),
    .rdData    (rdData),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .ramWe     (ramWe),
    .ramRe     (ramRe)
  );
endmodule

// File: tb/sim_wram_port_top.sv
`timescale 1ns/1ps
module sim_wram_port_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrStb, rdStb;
  logic [1:0]  wrSel, rdSel;
  logic [7:0]  wrData, openBus;
  logic [7:0]  rdData, ramWrData, ramRdData;
  logic [23:0] ramAddr;
  logic        ramWe, ramRe;

  int errors = 0;
  int checks = 0;
  logic [16:0] refPtr;
  logic [7:0]  shadow [int];
  logic [7:0]  ramMem [int];
  logic [7:0]  expQ [$];
  string       tagQ [$];
  logic        armNext = 1'b0;
  logic        monArm;

  always #2 clk = ~clk; // 250 MHz

  wram_port_top u0 (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrSel(wrSel), .wrData(wrData),
    .rdStb(rdStb), .rdSel(rdSel), .openBus(openBus), .rdData(rdData),
    .ramAddr(ramAddr), .ramWrData(ramWrData), .ramWe(ramWe), .ramRe(ramRe),
    .ramRdData(ramRdData)
  );

  function automatic logic [7:0] fillByte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // synchronous RAM model, one cycle read latency
  always @(posedge clk) begin
    if (ramWe) ramMem[int'(ramAddr)] = ramWrData;
    if (ramRe) ramRdData <= ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : fillByte(ramAddr);
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the expected read byte in the cycle after each read strobe
  always @(posedge clk) begin
    monArm = armNext;
    #2;
    if (monArm && expQ.size() > 0) begin
      string t;
      logic [7:0] e;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, "rdData", 32'(rdData), 32'(e));
    end
  end

  // driver: one register-bus cycle, model update and same-cycle RAM-side checks
  task automatic drive(input string req, input logic wE, input logic [1:0] wS, input logic [7:0] wD,
                       input logic rE, input logic [1:0] rS);
    logic dataWr, dataRd, addrWr;
    logic [23:0] a;
    dataWr = wE && wS == 2'd0;
    addrWr = wE && wS != 2'd0;
    dataRd = rE && rS == 2'd0 && !wE;
    a = 24'h7E0000 | 24'(refPtr);
    wrStb = wE; wrSel = wS; wrData = wD; rdStb = rE; rdSel = rS;
    armNext = rE;
    if (rE) begin
      expQ.push_back(dataRd ? (shadow.exists(int'(a)) ? shadow[int'(a)] : fillByte(a)) : openBus);
      tagQ.push_back(req);
    end
    #1;
    check(req, "ramWe", 32'(ramWe), 32'(dataWr));
    check(req, "ramRe", 32'(ramRe), 32'(dataRd));
    if (dataWr || dataRd) check(req, "ramAddr", 32'(ramAddr), 32'(a));
    if (dataWr) begin
      check(req, "ramWrData", 32'(ramWrData), 32'(wD));
      shadow[int'(a)] = wD;
    end
    if (addrWr) begin
      case (wS)
        2'd1: refPtr[7:0]  = wD;
        2'd2: refPtr[15:8] = wD;
        default: refPtr[16] = wD[0];
      endcase
    end else if (dataWr || dataRd) begin
      refPtr = refPtr + 17'd1;
    end
    @(posedge clk); #1;
    wrStb = 0; rdStb = 0; wrSel = 0; rdSel = 0; wrData = 0;
    armNext = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chkPtr(input string req);
    check(req, "ramAddr/pointer", 32'(ramAddr), 32'(24'h7E0000 | 24'(refPtr)));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rstN = 0; wrStb = 0; rdStb = 0; wrSel = 0; rdSel = 0; wrData = 0;
    openBus = 8'h5A; refPtr = '0;
    idle(3);
    rstN = 1;
    #0.5;
    // R1 reset state
    check("R1", "ramAddr", 32'(ramAddr), 32'h7E0000);
    check("R1", "ramWe", 32'(ramWe), 0);
    check("R1", "ramRe", 32'(ramRe), 0);
    check("R1", "rdData", 32'(rdData), 32'(openBus));
    idle(1);

    // pointer byte loads R2 R3 R4
    drive("R2", 1, 2'd1, 8'h34, 0, 0); chkPtr("R2");
    drive("R3", 1, 2'd2, 8'h12, 0, 0); chkPtr("R3");
    drive("R4", 1, 2'd3, 8'hFF, 0, 0); chkPtr("R4");
    check("R4", "ramAddr", 32'(ramAddr), 32'h7F1234);
    drive("R2", 1, 2'd1, 8'hAB, 0, 0); chkPtr("R2");
    check("R2", "ramAddr", 32'(ramAddr), 32'h7F12AB);
    drive("R4", 1, 2'd3, 8'hFE, 0, 0); chkPtr("R4");
    check("R4", "ramAddr", 32'(ramAddr), 32'h7E12AB);

    // data writes stream R5
    drive("R5", 1, 2'd0, 8'hC1, 0, 0);
    drive("R5", 1, 2'd0, 8'hC2, 0, 0);
    drive("R5", 1, 2'd0, 8'hC3, 0, 0);
    chkPtr("R5");
    check("R5", "ramAddr", 32'(ramAddr), 32'h7E12AE);

    // rewind and read back-to-back R6
    drive("R2", 1, 2'd1, 8'hAB, 0, 0);
    drive("R6", 0, 2'd0, 8'h00, 1, 2'd0);
    drive("R6", 0, 2'd0, 8'h00, 1, 2'd0);
    drive("R6", 0, 2'd0, 8'h00, 1, 2'd0);
    drive("R6", 0, 2'd0, 8'h00, 1, 2'd0); // unwritten location, fill byte
    chkPtr("R6");
    idle(1);

    // address-register reads R7
    openBus = 8'h96;
    idle(1);
    check("R7", "rdData idle", 32'(rdData), 32'(openBus));
    drive("R7", 0, 2'd0, 8'h00, 1, 2'd2);
    drive("R7", 0, 2'd0, 8'h00, 1, 2'd3);
    chkPtr("R7");
    idle(1);

    // wrap R8
    drive("R8", 1, 2'd1, 8'hFF, 0, 0);
    drive("R8", 1, 2'd2, 8'hFF, 0, 0);
    drive("R8", 1, 2'd3, 8'h01, 0, 0);
    check("R8", "ramAddr top", 32'(ramAddr), 32'h7FFFFF);
    drive("R8", 1, 2'd0, 8'h77, 0, 0);
    chkPtr("R8");
    check("R8", "ramAddr wrapped", 32'(ramAddr), 32'h7E0000);
    drive("R8", 1, 2'd3, 8'h01, 0, 0); // back to 0x10000
    drive("R8", 1, 2'd2, 8'hFF, 0, 0);
    drive("R8", 1, 2'd1, 8'hFF, 0, 0);
    drive("R8", 0, 2'd0, 8'h00, 1, 2'd0); // reads 0x77 from 0x7FFFFF
    chkPtr("R8");

    // address write with simultaneous data read R9
    drive("R9", 1, 2'd1, 8'h40, 1, 2'd0);
    chkPtr("R9");
    check("R9", "ramAddr", 32'(ramAddr), 32'h7E0040);
    idle(1);

    // data write with simultaneous data read R10
    drive("R10", 1, 2'd0, 8'hE5, 1, 2'd0);
    chkPtr("R10");
    check("R10", "ramAddr", 32'(ramAddr), 32'h7E0041);
    drive("R2", 1, 2'd1, 8'h40, 0, 0);
    drive("R10", 0, 2'd0, 8'h00, 1, 2'd0);
    idle(3);

    check("R6", "queue drained", 32'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule